// File: doc/BRIEF.md
# Selectable Configuration Word Bank

This block keeps four configuration words of six bytes each for a frequency synthesiser, together with a select register that chooses which word drives the synthesiser. A byte-wide register port writes and reads the bank. That port is typically driven by a serial-bus slave, which also supplies a one-cycle pulse when it detects the end of a bus transaction (STOP). Reset reloads every word from parameter defaults and points the selection at word 0.

Software reprograms a word that is not in use, then writes the select register. The new selection is held pending and takes effect only at the next STOP. Writes aimed at the word in use are dropped, so the live configuration never changes byte by byte. Each switch raises a one-cycle reload request and a busy flag. The busy flag covers a parameterised settling window, during which the downstream clock must be treated as invalid.

Top module: `cfg_word_bank`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) loads every word from `DEFAULT_WORDS` and sets the select register to 0. After reset, `active_cfg` equals default word 0, and `reload_pulse` and `relock_busy` are low.
- R2: Word w, byte b (b = 0..5) sits at address 10h + 6*w + b. Byte 0, the lowest address, is bits [47:40] of the 48-bit word. Default word w occupies bits [48*w+47 : 48*w] of `DEFAULT_WORDS`.
- R3: A write to a byte of a word other than the one currently active is stored at the clock edge that samples it. It reads back afterwards.
- R4: A write to a byte of the currently active word has no effect. Its readback and `active_cfg` keep their old values.
- R5: Writes to any address outside 10h–27h and 40h have no effect. Reads from those addresses return 00h.
- R6: The select register is at 40h. Bits [1:0] hold the requested word index. Reads of 40h return the last value written, with bits [7:2] always reading 0.
- R7: A select write does not change `active_cfg` until a clock edge samples `bus_stop` high. From the cycle after that edge, `active_cfg` shows the requested word and `reload_pulse` is high for exactly that one cycle.
- R8: A `bus_stop` with no select write since the previous switch produces no reload pulse, no busy window and no change of `active_cfg`.
- R9: A select write sampled at the same edge as `bus_stop` is committed by that STOP.
- R10: `relock_busy` goes high in the same cycle as `reload_pulse` and stays high for exactly `RELOCK_CYCLES` cycles. A further switch during the window restarts the full count.
- R11: `rd_data` reflects `reg_addr` combinationally, with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Byte address for both write and read |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `reg_addr` |
| bus_stop | input | 1 | One-cycle end-of-transaction pulse |
| active_cfg | output | 48 | Configuration word currently in use |
| reload_pulse | output | 1 | One-cycle request to reload the synthesiser |
| relock_busy | output | 1 | High while the synthesiser is settling |

## Verification
Two functions can fall in the same cycle: a write to the select register and the STOP pulse that commits selections. The bench drives `wr_en` to 40h and `bus_stop` together, then expects `reload_pulse` one cycle later, with `active_cfg` already showing the word just written. Two further collisions are checked: a second switch inside the busy window, which must restart the full count, and a write to the newly active word, which must be refused.

// File: rtl/cfgbank_pkg.sv
// Shared types for the configuration word bank.
// Assumes byte-wide register access throughout.
package cfgbank_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/cfgbank_decode.sv
// Address decoder: turns a byte address into a one-hot word hit, a byte
// index within that word, and a hit on the select register.
// Assumes every word address range fits inside ADDR_W bits.
module cfgbank_decode #(
    parameter int NUM_WORDS  = 4,
    parameter int WORD_BYTES = 6,
    parameter int ADDR_W     = 8,
    parameter int BASE_ADDR  = 16,
    parameter int SEL_ADDR   = 64,
    localparam int BI_W      = $clog2(WORD_BYTES)
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_WORDS-1:0] word_hit,
    output logic [BI_W-1:0]      byte_idx,
    output logic                 sel_hit
);
    // One range compare per word
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_hit
        localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE_ADDR + w*WORD_BYTES);
        localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE_ADDR + (w+1)*WORD_BYTES);
        assign word_hit[w] = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    end

    // Byte offset relative to the base of the hit word
    always_comb begin
        byte_idx = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_hit[w]) begin
                byte_idx = BI_W'(addr - ADDR_W'(BASE_ADDR + w*WORD_BYTES));
            end
        end
    end

    assign sel_hit = (addr == ADDR_W'(SEL_ADDR));
endmodule

// File: rtl/cfgbank_store.sv
// Byte storage for all configuration words, with the guard that drops
// writes to the word in use. Reset reloads each word from DEFAULT_WORDS.
// Assumes byte_idx is valid whenever the corresponding word_hit is set.
module cfgbank_store
    import cfgbank_pkg::*;
#(
    parameter int NUM_WORDS  = 4,
    parameter int WORD_BYTES = 6,
    parameter int SEL_W      = 2,
    localparam int WORD_W    = WORD_BYTES * BYTE_W,
    localparam int BI_W      = $clog2(WORD_BYTES),
    parameter logic [NUM_WORDS*WORD_W-1:0] DEFAULT_WORDS = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [NUM_WORDS-1:0]        word_hit,
    input  logic [BI_W-1:0]             byte_idx,
    input  byte_t                       wr_data,
    input  logic [SEL_W-1:0]            active_sel,
    output logic [NUM_WORDS*WORD_W-1:0] words_flat
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        byte_t mem [WORD_BYTES];
        logic  we;

        // Accept a write only when this word is not the one in use
        assign we = wr_en && word_hit[w] && (active_sel != SEL_W'(w));

        // Byte registers: default on reset, guarded update otherwise
        always_ff @(posedge clk) begin
            for (int b = 0; b < WORD_BYTES; b++) begin
                if (!rst_n) begin
                    mem[b] <= DEFAULT_WORDS[w*WORD_W + (WORD_BYTES-1-b)*BYTE_W +: BYTE_W];
                end else if (we && (int'(byte_idx) == b)) begin
                    mem[b] <= wr_data;
                end
            end
        end

        // Lowest address byte lands in the most significant position
        for (genvar b = 0; b < WORD_BYTES; b++) begin : g_pack
            assign words_flat[w*WORD_W + (WORD_BYTES-1-b)*BYTE_W +: BYTE_W] = mem[b];
        end
    end
endmodule

// File: rtl/cfgbank_select.sv
// Select register with deferred commit. A write is held pending and
// applied on the next bus STOP. A write in the STOP cycle itself is
// included. Each commit pulses reload for one cycle.
module cfgbank_select #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             bus_stop,
    output logic [SEL_W-1:0] pending_sel,
    output logic [SEL_W-1:0] active_sel,
    output logic             commit,
    output logic             reload_pulse
);
    logic             pend_valid;
    logic [SEL_W-1:0] eff_sel;

    // Forward a same-cycle write into the commit path
    assign eff_sel = sel_wr ? sel_wdata : pending_sel;
    assign commit  = bus_stop && (sel_wr || pend_valid);

    // Pending value, commit bookkeeping and the live selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_sel  <= '0;
            pend_valid   <= 1'b0;
            active_sel   <= '0;
            reload_pulse <= 1'b0;
        end else begin
            pending_sel  <= eff_sel;
            pend_valid   <= commit ? 1'b0 : (sel_wr || pend_valid);
            reload_pulse <= commit;
            if (commit) begin
                active_sel <= eff_sel;
            end
        end
    end
endmodule

// File: rtl/cfgbank_relock.sv
// Settling window timer: loads RELOCK_CYCLES on start and counts down.
// Busy is high while the count is non-zero. Assumes RELOCK_CYCLES >= 1.
module cfgbank_relock #(
    parameter int RELOCK_CYCLES = 100000,
    localparam int CNT_W        = $clog2(RELOCK_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] cnt;

    // Reload on every start, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(RELOCK_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/cfg_word_bank.sv
// Configuration word bank top. It ties together the decode, the guarded
// storage, the deferred select and the relock timer, and muxes the active
// word and the read data. Assumes one register access per cycle through
// a shared address.
module cfg_word_bank
    import cfgbank_pkg::*;
#(
    parameter int NUM_WORDS     = 4,
    parameter int WORD_BYTES    = 6,
    parameter int ADDR_W        = 8,
    parameter int BASE_ADDR     = 16,
    parameter int SEL_ADDR      = 64,
    parameter int RELOCK_CYCLES = 100000,
    localparam int WORD_W       = WORD_BYTES * BYTE_W,
    localparam int SEL_W        = $clog2(NUM_WORDS),
    localparam int BI_W         = $clog2(WORD_BYTES),
    parameter logic [NUM_WORDS*WORD_W-1:0] DEFAULT_WORDS = {
        48'h3C_11_40_00_00_04, 48'h3C_11_20_00_00_03,
        48'h3C_11_00_00_00_02, 48'h3C_10_E0_00_00_01}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              bus_stop,
    output logic [WORD_W-1:0] active_cfg,
    output logic              reload_pulse,
    output logic              relock_busy
);
    logic [NUM_WORDS-1:0]        word_hit;
    logic [BI_W-1:0]             byte_idx;
    logic                        sel_hit;
    logic [SEL_W-1:0]            pending_sel;
    logic [SEL_W-1:0]            active_sel;
    logic                        commit;
    logic [NUM_WORDS*WORD_W-1:0] words_flat;

    cfgbank_decode #(
        .NUM_WORDS(NUM_WORDS), .WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W),
        .BASE_ADDR(BASE_ADDR), .SEL_ADDR(SEL_ADDR)
    ) u_decode (
        .addr(reg_addr), .word_hit(word_hit), .byte_idx(byte_idx), .sel_hit(sel_hit)
    );

    cfgbank_store #(
        .NUM_WORDS(NUM_WORDS), .WORD_BYTES(WORD_BYTES), .SEL_W(SEL_W),
        .DEFAULT_WORDS(DEFAULT_WORDS)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_hit(word_hit),
        .byte_idx(byte_idx), .wr_data(wr_data), .active_sel(active_sel),
        .words_flat(words_flat)
    );

    cfgbank_select #(.SEL_W(SEL_W)) u_select (
        .clk(clk), .rst_n(rst_n), .sel_wr(wr_en && sel_hit),
        .sel_wdata(wr_data[SEL_W-1:0]), .bus_stop(bus_stop),
        .pending_sel(pending_sel), .active_sel(active_sel),
        .commit(commit), .reload_pulse(reload_pulse)
    );

    cfgbank_relock #(.RELOCK_CYCLES(RELOCK_CYCLES)) u_relock (
        .clk(clk), .rst_n(rst_n), .start(commit), .busy(relock_busy)
    );

    // Live configuration follows the committed selection
    assign active_cfg = words_flat[int'(active_sel)*WORD_W +: WORD_W];

    // Read mux: word bytes, select register, zero elsewhere
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_hit[w]) begin
                rd_data = words_flat[w*WORD_W + (WORD_BYTES-1-int'(byte_idx))*BYTE_W +: BYTE_W];
            end
        end
        if (sel_hit) begin
            rd_data = byte_t'(pending_sel);
        end
    end
endmodule

// File: rtl/cfgbank_checker.sv
// Property checker for cfg_word_bank, attached by bind below.
module cfgbank_checker #(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 16,
    parameter int SEL_ADDR  = 64,
    parameter int SPAN      = 24,
    parameter int WORD_W    = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        rd_data,
    input logic              bus_stop,
    input logic [WORD_W-1:0] active_cfg,
    input logic              reload_pulse,
    input logic              relock_busy
);
    logic unmapped;
    assign unmapped = (int'(reg_addr) < BASE_ADDR || int'(reg_addr) >= BASE_ADDR + SPAN)
                      && (int'(reg_addr) != SEL_ADDR);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!reload_pulse && !relock_busy));

    p_cfg_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_pulse |-> $stable(active_cfg));

    p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (rd_data == 8'h00));

    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr) == SEL_ADDR) |-> (rd_data[7:2] == 6'b0));

    p_reload_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pulse |-> $past(bus_stop));

    p_busy_with_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pulse |-> relock_busy);
endmodule

bind cfg_word_bank cfgbank_checker #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .SEL_ADDR(SEL_ADDR),
    .SPAN(NUM_WORDS*WORD_BYTES), .WORD_W(WORD_W)
) u_cfgbank_checker (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_data(rd_data),
    .bus_stop(bus_stop), .active_cfg(active_cfg),
    .reload_pulse(reload_pulse), .relock_busy(relock_busy)
);

// File: tb/cfg_word_bank_bench.sv
`timescale 1ns/1ps
module cfg_word_bank_bench;
    localparam int RELOCK = 12;
    localparam logic [47:0] W0 = 48'hA0A1A2A3A4A5;
    localparam logic [47:0] W1 = 48'hB0B1B2B3B4B5;
    localparam logic [47:0] W2 = 48'hC0C1C2C3C4C5;
    localparam logic [47:0] W3 = 48'hD0D1D2D3D4D5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic        bus_stop = 1'b0;
    logic [47:0] active_cfg;
    logic        reload_pulse;
    logic        relock_busy;

    int checks = 0;
    int failures = 0;

    cfg_word_bank #(
        .RELOCK_CYCLES(RELOCK),
        .DEFAULT_WORDS({W3, W2, W1, W0})
    ) u_cfg_word_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .bus_stop(bus_stop),
        .active_cfg(active_cfg), .reload_pulse(reload_pulse),
        .relock_busy(relock_busy)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic stop);
        reg_addr = a; wr_data = d; wr_en = 1'b1; bus_stop = stop;
        tick();
        wr_en = 1'b0; bus_stop = 1'b0;
    endtask

    task automatic stop_pulse();
        bus_stop = 1'b1;
        tick();
        bus_stop = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (relock_busy && n < 1000) begin
            n++;
            tick();
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 active word0", active_cfg, W0);
        chk("R1 busy low", 48'(relock_busy), 48'd0);
        chk("R1 reload low", 48'(reload_pulse), 48'd0);
        rd(8'h40, v); chk("R1 select zero", 48'(v), 48'h00);
    endtask

    task automatic t_read_map();
        logic [7:0] v;
        rd(8'h10, v); chk("R2 word0 byte0", 48'(v), 48'hA0);
        rd(8'h15, v); chk("R2 word0 byte5", 48'(v), 48'hA5);
        rd(8'h16, v); chk("R2 word1 byte0", 48'(v), 48'hB0);
        rd(8'h27, v); chk("R11 word3 byte5 same cycle", 48'(v), 48'hD5);
    endtask

    task automatic t_write_unselected();
        logic [7:0] v;
        wr(8'h1C, 8'h5A, 1'b0);
        rd(8'h1C, v); chk("R3 word2 byte0 stored", 48'(v), 48'h5A);
        chk("R3 active untouched", active_cfg, W0);
    endtask

    task automatic t_write_active();
        logic [7:0] v;
        wr(8'h12, 8'hFF, 1'b0);
        rd(8'h12, v); chk("R4 active byte kept", 48'(v), 48'hA2);
        chk("R4 active cfg kept", active_cfg, W0);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(8'h0F, 8'h77, 1'b0);
        wr(8'h28, 8'h77, 1'b0);
        wr(8'h41, 8'h77, 1'b0);
        rd(8'h0F, v); chk("R5 read 0F", 48'(v), 48'h00);
        rd(8'h28, v); chk("R5 read 28", 48'(v), 48'h00);
        rd(8'h10, v); chk("R5 neighbour 10 intact", 48'(v), 48'hA0);
        rd(8'h27, v); chk("R5 neighbour 27 intact", 48'(v), 48'hD5);
        rd(8'h40, v); chk("R5 select intact", 48'(v), 48'h00);
        chk("R5 no reload", 48'(reload_pulse), 48'd0);
    endtask

    task automatic t_select_deferred();
        logic [7:0] v;
        int n;
        wr(8'h40, 8'hFE, 1'b0);
        rd(8'h40, v); chk("R6 select readback reserved zero", 48'(v), 48'h02);
        tick(); tick();
        chk("R7 held before stop", active_cfg, W0);
        chk("R7 no pulse before stop", 48'(reload_pulse), 48'd0);
        stop_pulse();
        chk("R7 pulse after stop", 48'(reload_pulse), 48'd1);
        chk("R7 switched to word2", active_cfg, 48'h5AC1C2C3C4C5);
        tick();
        chk("R7 pulse one cycle", 48'(reload_pulse), 48'd0);
        count_busy(n);
        chk("R10 busy length", 48'(n + 1), 48'(RELOCK));
    endtask

    task automatic t_stop_no_pending();
        stop_pulse();
        chk("R8 no pulse", 48'(reload_pulse), 48'd0);
        chk("R8 no busy", 48'(relock_busy), 48'd0);
        chk("R8 cfg kept", active_cfg, 48'h5AC1C2C3C4C5);
    endtask

    task automatic t_coincide();
        logic [7:0] v;
        int n;
        wr(8'h40, 8'h01, 1'b1);
        chk("R9 pulse on same-cycle write", 48'(reload_pulse), 48'd1);
        chk("R9 word1 active", active_cfg, W1);
        rd(8'h40, v); chk("R9 select readback", 48'(v), 48'h01);
        repeat (5) tick();
        wr(8'h40, 8'h03, 1'b0);
        stop_pulse();
        chk("R10 restart pulse", 48'(reload_pulse), 48'd1);
        chk("R10 word3 active", active_cfg, W3);
        count_busy(n);
        chk("R10 restarted full window", 48'(n), 48'(RELOCK));
    endtask

    task automatic t_guard_after_switch();
        logic [7:0] v;
        wr(8'h22, 8'h11, 1'b0);
        rd(8'h22, v); chk("R4 new active word guarded", 48'(v), 48'hD0);
        wr(8'h10, 8'h22, 1'b0);
        rd(8'h10, v); chk("R3 former active now writable", 48'(v), 48'h22);
        chk("R4 cfg kept", active_cfg, W3);
    endtask

    task automatic t_reset_again();
        logic [7:0] v;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        chk("R1 reset back to word0", active_cfg, W0);
        rd(8'h1C, v); chk("R1 word2 default restored", 48'(v), 48'hC0);
        rd(8'h40, v); chk("R1 select cleared", 48'(v), 48'h00);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_read_map();
        t_write_unselected();
        t_write_active();
        t_unmapped();
        t_select_deferred();
        t_stop_no_pending();
        t_coincide();
        t_guard_after_switch();
        t_reset_again();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule